// File: doc/BRIEF.md
# Fuse Array Read Controller

A register-mapped read controller for a 512-byte one-time-programmable fuse array. Software powers the array up, enables automatic reads and writes a word address into the control register. It pulses an address-latch bit to capture that address and then pulses a start bit. While the fuse macro works, a busy flag reads as 1. When the flag drops, the fetched word sits in a read-only data register.

The fuse macro is a behavioural model inside the block. Its contents are computed from a fixed formula and it has a fixed access latency. Fields for the programming path and for encryption are plain storage: they read back what was written and do nothing else. Register reads are combinational from `addr_i`, so `rdata_o` is valid in the same cycle as the address. Writes take effect at the clock edge that ends the cycle in which `req_i` and `we_i` are high.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control register (offset 0x04) reads 0x0800_0000, meaning powered down with everything else clear. The data register (0x08) reads 0, the auxiliary register (0x10) reads 0, and the latched address is 0.
- R2: Only byte offsets 0x04, 0x08 and 0x10 are decoded. Any other offset reads 0, and writes to it change no register.
- R3: Control register fields read back as written: word address [10:0], latch strobe [11], program enable [12], program start [13], program data [23:16], read enable [24], read start [25] and power-down [27]. The auxiliary register stores only bit 10, the encrypt enable. Program-busy [14], bit 15 and bits [31:28] always read 0.
- R4: The latched word address changes only on a control write that takes bit 11 from 0 to 1. It then takes bits [10:0] of that write, modulo the number of words. A write that changes only the address field leaves the latched address, and so the next fetched word, unchanged.
- R5: A control write that takes bit 25 from 0 to 1 starts a read if, before that write, the block is powered up (bit 27 = 0), read-enabled (bit 24 = 1) and not busy. Bit 26 then reads 1 in each of the 8 cycles that follow the write. In the 9th cycle it reads 0, and the data register holds the word at the latched address.
- R6: A start strobe is ignored while powered down, while read enable is 0, or while a read is busy. Busy does not rise for it, the read in flight keeps its timing, and the data register keeps its value.
- R7: Fuse byte i (0..511) holds (29*i + 0x3C) mod 256. With word size W (4 by default, or 1), word a consists of bytes a*W..a*W+W-1, with byte a*W in bits [7:0]. A 1-byte word is zero-extended to 32 bits.
- R8: Bits 26 and 14 of the control register and the whole data register are read-only. Writes to them are ignored.
- R9: Writing 1 to a strobe bit that already holds 1 is not a rising edge. It neither starts a read nor latches an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, same cycle |

## Verification
The embedded assertions check on every cycle the following properties. An accepted start is followed by busy in the next cycle, and a start is never accepted twice in a row. The macro is never re-requested while its access is running, and macro data arrives only during busy. Busy never lasts beyond the macro latency, and the data register changes only when the macro returns a word. The exact busy window of 8 cycles, the fuse contents and the address wrap need the bench's reference model. So do the rules for ignored strobes, the rejection of a latch-free address change, and readback of the storage-only fields; the model checks all of these on each clock for both word sizes.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam logic [4:0] OFF_CTRL = 5'h04;
  localparam logic [4:0] OFF_DATA = 5'h08;
  localparam logic [4:0] OFF_AUX  = 5'h10;

  localparam int B_LATCH  = 11;
  localparam int B_WEN    = 12;
  localparam int B_WSTART = 13;
  localparam int B_WBUSY  = 14;
  localparam int B_REN    = 24;
  localparam int B_RSTART = 25;
  localparam int B_RBUSY  = 26;
  localparam int B_PD     = 27;
  localparam int B_ENC    = 10;

  typedef struct packed {
    logic        pd;
    logic        rd_start;
    logic        rd_en;
    logic [7:0]  wr_data;
    logic        wr_start;
    logic        wr_en;
    logic        latch;
    logic [10:0] waddr;
  } ctrl_t;
endpackage

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
  import fuse_rd_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [4:0]    addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          busy_i,
  input  logic [31:0]   data_i,
  output logic [31:0]   rdata_o,
  output logic          start_o,
  output logic [AW-1:0] laddr_o
);
  ctrl_t         ctrl_q;
  logic          enc_q;
  logic [AW-1:0] laddr_q;
  logic          wr_ctrl, wr_aux, latch_rise;

  assign wr_ctrl    = req_i && we_i && (addr_i == OFF_CTRL);
  assign wr_aux     = req_i && we_i && (addr_i == OFF_AUX);
  assign latch_rise = wr_ctrl && wdata_i[B_LATCH] && !ctrl_q.latch;
  // start gated on pre-write state
  assign start_o    = wr_ctrl && wdata_i[B_RSTART] && !ctrl_q.rd_start &&
                      !ctrl_q.pd && ctrl_q.rd_en && !busy_i;
  assign laddr_o    = laddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      ctrl_q.pd <= 1'b1;
      enc_q     <= 1'b0;
      laddr_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.pd       <= wdata_i[B_PD];
        ctrl_q.rd_start <= wdata_i[B_RSTART];
        ctrl_q.rd_en    <= wdata_i[B_REN];
        ctrl_q.wr_data  <= wdata_i[23:16];
        ctrl_q.wr_start <= wdata_i[B_WSTART];
        ctrl_q.wr_en    <= wdata_i[B_WEN];
        ctrl_q.latch    <= wdata_i[B_LATCH];
        ctrl_q.waddr    <= wdata_i[10:0];
      end
      if (wr_aux)     enc_q   <= wdata_i[B_ENC];
      if (latch_rise) laddr_q <= wdata_i[AW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: begin
        rdata_o[10:0]     = ctrl_q.waddr;
        rdata_o[B_LATCH]  = ctrl_q.latch;
        rdata_o[B_WEN]    = ctrl_q.wr_en;
        rdata_o[B_WSTART] = ctrl_q.wr_start;
        rdata_o[23:16]    = ctrl_q.wr_data;
        rdata_o[B_REN]    = ctrl_q.rd_en;
        rdata_o[B_RSTART] = ctrl_q.rd_start;
        rdata_o[B_RBUSY]  = busy_i;
        rdata_o[B_PD]     = ctrl_q.pd;
      end
      OFF_DATA: rdata_o = data_i;
      OFF_AUX:  rdata_o[B_ENC] = enc_q;
      default:  rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:28], wdata_i[B_RBUSY], wdata_i[15], wdata_i[B_WBUSY]};

  // R9: a stored strobe of 1 cannot be accepted again on the next write
  p_start_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R4: no latch edge, no address change
  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wdata_i[B_LATCH]) |=> $stable(laddr_o));
endmodule

// File: rtl/fuse_rd_array.sv
module fuse_rd_array #(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int LATENCY     = 8,
  parameter int AW          = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [AW-1:0]           addr_i,
  output logic                    valid_o,
  output logic [8*WORD_BYTES-1:0] data_o
);
  localparam int IW = $clog2(ARRAY_BYTES);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [7:0]    cells [ARRAY_BYTES];
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;

  for (genvar g = 0; g < ARRAY_BYTES; g++) begin : g_cell
    assign cells[g] = 8'((g * 29 + 60) % 256);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
    end else if (req_i) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(LATENCY - 1);
      addr_q   <= addr_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign valid_o = active_q && (cnt_q == '0);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic [IW-1:0] idx;
    assign idx = IW'(addr_q) * IW'(WORD_BYTES) + IW'(b);
    assign data_o[8*b +: 8] = cells[idx];
  end

  // R6: no new access while one is running
  p_req_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !active_q);
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int LATENCY = 8,
  parameter int DW      = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          busy_o,
  output logic [31:0]   data_o
);
  localparam int CW = $clog2(LATENCY + 1) + 1;

  logic        busy_q;
  logic [31:0] data_q;
  logic [CW-1:0] busy_cyc_q;

  assign req_o  = start_i;
  assign busy_o = busy_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (start_i)      busy_q <= 1'b1;
      else if (valid_i) busy_q <= 1'b0;
      if (valid_i && busy_q) data_q <= 32'(rdata_i);
    end
  end

  // cycles spent busy, for the latency bound below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cyc_q <= '0;
    else if (busy_q) busy_cyc_q <= busy_cyc_q + 1'b1;
    else             busy_cyc_q <= '0;
  end

  p_busy_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_valid_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> busy_q);
  p_busy_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (busy_cyc_q < CW'(LATENCY)));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl #(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int LATENCY     = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int WORDS = ARRAY_BYTES / WORD_BYTES;
  localparam int AW    = $clog2(WORDS);
  localparam int DW    = 8 * WORD_BYTES;

  logic          start, busy, mac_req, mac_valid;
  logic [AW-1:0] laddr;
  logic [DW-1:0] mac_data;
  logic [31:0]   data;

  fuse_rd_regs #(.AW(AW)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .data_i  (data),
    .rdata_o (rdata_o),
    .start_o (start),
    .laddr_o (laddr)
  );

  fuse_rd_seq #(.LATENCY(LATENCY), .DW(DW)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .valid_i (mac_valid),
    .rdata_i (mac_data),
    .req_o   (mac_req),
    .busy_o  (busy),
    .data_o  (data)
  );

  fuse_rd_array #(
    .WORD_BYTES (WORD_BYTES),
    .ARRAY_BYTES(ARRAY_BYTES),
    .LATENCY    (LATENCY),
    .AW         (AW)
  ) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (mac_req),
    .addr_i  (laddr),
    .valid_o (mac_valid),
    .data_o  (mac_data)
  );
endmodule

// File: tb/test_fuse_rd_ctrl.sv
module test_fuse_rd_ctrl;
  localparam logic [31:0] PD  = 32'h0800_0000;
  localparam logic [31:0] REN = 32'h0100_0000;
  localparam logic [31:0] STR = 32'h0200_0000;
  localparam logic [31:0] LAT = 32'h0000_0800;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req, we;
  logic [4:0]  addr;
  logic [31:0] wdata, rd4, rd1;

  fuse_rd_ctrl i_fuse_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd4));
  fuse_rd_ctrl #(.WORD_BYTES(1)) i_fuse_rd_ctrl_w1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd1));

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // reference model state
  logic [10:0] m_addr, m_laddr, m_cap;
  logic [7:0]  m_wdat;
  logic m_latch, m_wen, m_wst, m_ren, m_rst, m_pd, m_enc, m_busy;
  int m_left;
  logic [31:0] m_d4, m_d1;

  function automatic logic [7:0] fbyte(int i);
    return 8'((i * 29 + 60) % 256);
  endfunction

  function automatic logic [31:0] fword(int a, int wb);
    logic [31:0] w = '0;
    int aa = a % (512 / wb);
    for (int b = 0; b < wb; b++) w[8*b +: 8] = fbyte(aa * wb + b);
    return w;
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a, bit one);
    logic [31:0] r = '0;
    case (a)
      5'h04: begin
        r[10:0] = m_addr; r[11] = m_latch; r[12] = m_wen; r[13] = m_wst;
        r[23:16] = m_wdat; r[24] = m_ren; r[25] = m_rst; r[26] = m_busy; r[27] = m_pd;
      end
      5'h08: r = one ? m_d1 : m_d4;
      5'h10: r[10] = m_enc;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string inst);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", cur_req, inst, addr, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic w, logic [4:0] a, logic [31:0] d);
    logic old_busy;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    #1;
    chk(rd4, exp_rd(a, 1'b0), "w4");
    chk(rd1, exp_rd(a, 1'b1), "w1");
    @(posedge clk);
    old_busy = m_busy;
    if (old_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_d4 = fword(int'(m_cap), 4);
        m_d1 = fword(int'(m_cap), 1);
        m_busy = 1'b0;
      end
    end
    if (r && w && a == 5'h04) begin
      if (d[25] && !m_rst && !m_pd && m_ren && !old_busy) begin
        m_busy = 1'b1; m_left = 8; m_cap = m_laddr;
      end
      if (d[11] && !m_latch) m_laddr = d[10:0];
      m_addr = d[10:0]; m_latch = d[11]; m_wen = d[12]; m_wst = d[13];
      m_wdat = d[23:16]; m_ren = d[24]; m_rst = d[25]; m_pd = d[27];
    end
    if (r && w && a == 5'h10) m_enc = d[10];
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d); cyc(1'b1, 1'b1, a, d); endtask
  task automatic rd(logic [4:0] a);                 cyc(1'b1, 1'b0, a, 32'h0); endtask
  task automatic poll(int n); for (int i = 0; i < n; i++) rd(5'h04); endtask

  // full read: latch address, start, watch busy, read data
  task automatic fetch(logic [10:0] wa);
    wr(5'h04, REN | 32'(wa));
    wr(5'h04, REN | LAT | 32'(wa));
    wr(5'h04, REN | 32'(wa));
    wr(5'h04, REN | STR | 32'(wa));
    wr(5'h04, REN | 32'(wa));
    poll(9);
    rd(5'h08);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    m_addr = '0; m_laddr = '0; m_cap = '0; m_wdat = '0;
    m_latch = 0; m_wen = 0; m_wst = 0; m_ren = 0; m_rst = 0; m_pd = 1; m_enc = 0;
    m_busy = 0; m_left = 0; m_d4 = '0; m_d1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1"; rd(5'h04); rd(5'h08); rd(5'h10);

    cur_req = "R2";
    rd(5'h00); rd(5'h0C); rd(5'h14); rd(5'h05);
    wr(5'h00, '1); wr(5'h0C, '1); wr(5'h18, '1);
    rd(5'h04); rd(5'h10);

    cur_req = "R3";
    wr(5'h04, 32'hF9AB_F5A5); rd(5'h04);
    wr(5'h10, '1); rd(5'h10); wr(5'h10, 32'h0); rd(5'h10);

    cur_req = "R8";
    wr(5'h04, PD | 32'h0400_4000); rd(5'h04);
    wr(5'h08, '1); rd(5'h08);

    cur_req = "R6";   // powered down
    wr(5'h04, PD | REN); wr(5'h04, PD | REN | STR); poll(4); rd(5'h08);
    wr(5'h04, PD | REN);
    wr(5'h04, 32'h0); wr(5'h04, STR); poll(4); rd(5'h08);  // read disabled
    wr(5'h04, 32'h0);

    cur_req = "R5"; fetch(11'd5);
    cur_req = "R7"; fetch(11'd127); fetch(11'd300);

    cur_req = "R4";   // field change without latch edge
    wr(5'h04, REN | 32'd9);
    wr(5'h04, REN | STR | 32'd9); wr(5'h04, REN | 32'd9); poll(9); rd(5'h08);
    fetch(11'd130);

    cur_req = "R9";
    wr(5'h04, REN | STR | 32'd3); poll(9);
    wr(5'h04, REN | STR | 32'd40); poll(9); rd(5'h08);
    wr(5'h04, REN | LAT | 32'd60); wr(5'h04, REN | LAT | 32'd61);
    wr(5'h04, REN); wr(5'h04, REN | STR); poll(9); rd(5'h08);
    wr(5'h04, REN);

    cur_req = "R6";   // strobe while busy
    wr(5'h04, REN | LAT | 32'd77); wr(5'h04, REN);
    wr(5'h04, REN | STR); wr(5'h04, REN); rd(5'h04);
    wr(5'h04, REN | LAT | 32'd20); wr(5'h04, REN);
    wr(5'h04, REN | STR); wr(5'h04, REN); poll(8); rd(5'h08);
    wr(5'h04, PD);
    rd(5'h04);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule